// File: doc/BRIEF.md
# Card Feed Fault Supervisor

This block runs the pick-and-feed cycle of a card reader mechanism and protects it. A read request from IDLE starts a pick: the block pulses a pick command for one cycle, keeps the feed motor enabled, and waits for the card-present sensor. If the card does not show up within a programmable number of cycles, it picks again. Three misses in a row end in a pick-failure fault. Once a card is under the read station, the block times how long it stays there. A card that stays longer than a programmable transit limit is treated as a jam.

Two more sensors are watched in every state except FAULT: input hopper empty and output stacker full. Any fault sends the block to FAULT. In FAULT the motor enable drops, feeding stops and a 3-bit fault code is reported. The block stays there until the fault clear input is pulsed. All three raw sensor inputs pass through a two-flop synchroniser before they are used.

Top module: `card_feed_supervisor`

## Requirements
- R1: After reset the block is idle: `motor_en` is 0, `pick` is 0, `card_done` is 0 and `fault_code` is 0.
- R2: A `read_req` pulse in IDLE with no fault gives exactly one single-cycle `pick` pulse. `motor_en` is 1 while a pick, a wait for the card or a read is in progress.
- R3: If the card-present sensor asserts within `pick_timeout` cycles of the wait starting, no further pick is made. When the sensor deasserts, `card_done` pulses for one cycle, and the block returns to IDLE with `motor_en` at 0 and `fault_code` at 0.
- R4: A pick with no card present for `pick_timeout` cycles is retried. The third consecutive miss sets `fault_code` to 3 (pick failure) after exactly three `pick` pulses, with `motor_en` at 0.
- R5: A successful pick clears the count of consecutive misses, so two misses followed by a success on each of two requests cause no fault.
- R6: An asserted hopper-empty sensor, whether idle or feeding, sets `fault_code` to 1 and forces `motor_en` to 0.
- R7: An asserted stacker-full sensor sets `fault_code` to 2 and forces `motor_en` to 0.
- R8: A card-present sensor that stays high for `max_transit` cycles in the read phase sets `fault_code` to 4 (jam) and forces `motor_en` to 0.
- R9: When several faults are detected in the same cycle, the code taken follows this priority: jam (4), then pick failure (3), then stacker full (2), then hopper empty (1). The code is never above 4.
- R10: In FAULT the code and the motor-off state hold, even when the sensors return to normal or `read_req` pulses. A `fault_clear` pulse returns the block to IDLE with `fault_code` 0.
- R11: `fault_clear` outside FAULT has no effect: it neither starts a pick nor aborts a card being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| read_req | input | 1 | Request to feed and read one card, sampled in IDLE |
| fault_clear | input | 1 | Pulse that leaves the FAULT state |
| pick_timeout | input | TMR_W | Cycles allowed for a card to appear after a pick |
| max_transit | input | TMR_W | Longest allowed card-present time before a jam is declared |
| card_sense | input | 1 | Raw card-present sensor at the read station |
| hopper_empty | input | 1 | Raw input-hopper-empty sensor |
| stacker_full | input | 1 | Raw output-stacker-full sensor |
| pick | output | 1 | Single-cycle pick command |
| motor_en | output | 1 | Feed motor enable |
| card_done | output | 1 | One-cycle pulse when a card has passed the read station |
| fault_code | output | 3 | 0 none, 1 hopper empty, 2 stacker full, 3 pick failure, 4 jam |

## Verification
On every cycle the assertions check the following:
- each pick pulse lasts a single cycle and occurs with the motor on;
- the motor is off whenever a fault code is shown;
- a shown code stays put until a clear;
- the code stays within its five values;
- the miss counter never reaches the retry limit;
- `card_done` appears only with the motor stopped.

Some behaviour is visible only in the bench scenarios:
- the exact count of pick pulses before a pick failure;
- that retries are forgiven after a success;
- the code chosen for each sensor condition and for simultaneous faults;
- the jam timing against the transit limit;
- that clear is ignored outside FAULT.

// File: rtl/card_feed_supervisor.sv
module card_feed_supervisor #(
  parameter int TMR_W     = 16,
  parameter int MAX_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             read_req,
  input  logic             fault_clear,
  input  logic [TMR_W-1:0] pick_timeout,
  input  logic [TMR_W-1:0] max_transit,
  input  logic             card_sense,
  input  logic             hopper_empty,
  input  logic             stacker_full,
  output logic             pick,
  output logic             motor_en,
  output logic             card_done,
  output logic [2:0]       fault_code
);

  localparam int RW = $clog2(MAX_TRIES + 1);

  localparam logic [2:0] CODE_NONE    = 3'd0;
  localparam logic [2:0] CODE_HOPPER  = 3'd1;
  localparam logic [2:0] CODE_STACKER = 3'd2;
  localparam logic [2:0] CODE_PICK    = 3'd3;
  localparam logic [2:0] CODE_JAM     = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_WAIT, S_READ, S_FAULT} state_t;

  state_t           state_q;
  logic [TMR_W-1:0] timer_q;
  logic [RW-1:0]    retry_q;
  logic [2:0]       code_q;
  logic             done_q;
  logic [2:0]       sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= {stacker_full, hopper_empty, card_sense};
      sync2_q <= sync1_q;
    end

  wire card_s    = sync2_q[0];
  wire hopper_s  = sync2_q[1];
  wire stacker_s = sync2_q[2];

  wire [TMR_W:0] tick      = {1'b0, timer_q} + {{TMR_W{1'b0}}, 1'b1};
  wire           pick_due  = tick >= {1'b0, pick_timeout};
  wire           jam_due   = tick >= {1'b0, max_transit};

  wire jam_hit   = (state_q == S_READ) && card_s && jam_due;
  wire pick_miss = (state_q == S_WAIT) && !card_s && pick_due;
  wire pick_fail = pick_miss && (retry_q == RW'(MAX_TRIES - 1));

  logic [2:0] new_code;
  always_comb begin
    if (state_q == S_FAULT)  new_code = CODE_NONE;
    else if (jam_hit)        new_code = CODE_JAM;
    else if (pick_fail)      new_code = CODE_PICK;
    else if (stacker_s)      new_code = CODE_STACKER;
    else if (hopper_s)       new_code = CODE_HOPPER;
    else                     new_code = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= S_IDLE;
      timer_q <= '0;
      retry_q <= '0;
      code_q  <= CODE_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (new_code != CODE_NONE) begin
        state_q <= S_FAULT;
        code_q  <= new_code;
      end else begin
        case (state_q)
          S_IDLE:
            if (read_req) state_q <= S_PICK;
          S_PICK: begin
            state_q <= S_WAIT;
            timer_q <= '0;
          end
          S_WAIT:
            if (card_s) begin
              state_q <= S_READ;
              timer_q <= '0;
              retry_q <= '0;
            end else if (pick_miss) begin
              state_q <= S_PICK;
              retry_q <= retry_q + RW'(1);
            end else begin
              timer_q <= timer_q + TMR_W'(1);
            end
          S_READ:
            if (!card_s) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              timer_q <= timer_q + TMR_W'(1);
            end
          S_FAULT:
            if (fault_clear) begin
              state_q <= S_IDLE;
              code_q  <= CODE_NONE;
              retry_q <= '0;
            end
          default: state_q <= S_IDLE;
        endcase
      end
    end

  assign pick       = (state_q == S_PICK);
  assign motor_en   = (state_q == S_PICK) || (state_q == S_WAIT) || (state_q == S_READ);
  assign card_done  = done_q;
  assign fault_code = code_q;

  AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pick |=> !pick); // R2
  AST_PICK_MOTOR: assert property (@(posedge clk) disable iff (!rst_n) pick |-> motor_en); // R2
  AST_DONE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) card_done |-> !motor_en); // R3
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) retry_q < RW'(MAX_TRIES)); // R4
  AST_FAULT_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n) (fault_code != 3'd0) |-> !motor_en); // R6
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) fault_code <= 3'd4); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fault_code != 3'd0 && !fault_clear) |=> $stable(fault_code)); // R10

endmodule

// File: tb/card_feed_supervisor_tb.sv
module card_feed_supervisor_tb;
  localparam int TMR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic read_req = 1'b0, fault_clear = 1'b0;
  logic [TMR_W-1:0] pick_timeout = 16'd20, max_transit = 16'd30;
  logic card_sense = 1'b0, hopper_empty = 1'b0, stacker_full = 1'b0;
  logic pick, motor_en, card_done;
  logic [2:0] fault_code;

  int checks = 0, errors = 0, cycles = 0;
  int pick_cnt = 0, done_cnt = 0;

  always #2 clk = ~clk;

  card_feed_supervisor #(.TMR_W(TMR_W), .MAX_TRIES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .read_req(read_req), .fault_clear(fault_clear),
    .pick_timeout(pick_timeout), .max_transit(max_transit),
    .card_sense(card_sense), .hopper_empty(hopper_empty), .stacker_full(stacker_full),
    .pick(pick), .motor_en(motor_en), .card_done(card_done), .fault_code(fault_code));

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && pick) pick_cnt <= pick_cnt + 1;
    if (rst_n && card_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    @(negedge clk) read_req = 1'b1;
    @(negedge clk) read_req = 1'b0;
  endtask

  task automatic clear_fault();
    @(negedge clk) fault_clear = 1'b1;
    @(negedge clk) fault_clear = 1'b0;
    cyc(1);
  endtask

  task automatic wait_picks(input int target);
    for (int i = 0; i < 500 && pick_cnt < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check(motor_en == 1'b0, "R1 motor", motor_en, 0);
    check(pick == 1'b0, "R1 pick", pick, 0);
    check(card_done == 1'b0, "R1 done", card_done, 0);
    check(fault_code == 3'd0, "R1 code", fault_code, 0);
  endtask

  task automatic t_normal();
    int p0 = pick_cnt, d0 = done_cnt;
    @(negedge clk) read_req = 1'b1;
    @(negedge clk) read_req = 1'b0;
    check(pick == 1'b1, "R2 pick pulse", pick, 1);
    check(motor_en == 1'b1, "R2 motor on", motor_en, 1);
    @(negedge clk);
    check(pick == 1'b0, "R2 pick single", pick, 0);
    card_sense = 1'b1;
    cyc(8);
    check(motor_en == 1'b1, "R2 motor while reading", motor_en, 1);
    card_sense = 1'b0;
    cyc(6);
    check(done_cnt - d0 == 1, "R3 card_done", done_cnt - d0, 1);
    check(pick_cnt - p0 == 1, "R3 no retry", pick_cnt - p0, 1);
    check(motor_en == 1'b0, "R3 motor off", motor_en, 0);
    check(fault_code == 3'd0, "R3 code", fault_code, 0);
  endtask

  task automatic t_pick_fail();
    int p0 = pick_cnt;
    request();
    cyc(100);
    check(pick_cnt - p0 == 3, "R4 pick count", pick_cnt - p0, 3);
    check(fault_code == 3'd3, "R4 code", fault_code, 3);
    check(motor_en == 1'b0, "R4 motor off", motor_en, 0);
    request();
    cyc(10);
    check(pick_cnt - p0 == 3, "R10 request ignored", pick_cnt - p0, 3);
    check(fault_code == 3'd3, "R10 code held", fault_code, 3);
    clear_fault();
    check(fault_code == 3'd0, "R10 cleared", fault_code, 0);
    check(motor_en == 1'b0, "R10 idle after clear", motor_en, 0);
  endtask

  task automatic t_retry_clear();
    int p0 = pick_cnt, d0 = done_cnt;
    for (int r = 1; r <= 2; r++) begin
      request();
      wait_picks(p0 + 3 * r);
      card_sense = 1'b1;
      cyc(5);
      card_sense = 1'b0;
      cyc(6);
    end
    check(pick_cnt - p0 == 6, "R5 picks", pick_cnt - p0, 6);
    check(done_cnt - d0 == 2, "R5 cards", done_cnt - d0, 2);
    check(fault_code == 3'd0, "R5 no fault", fault_code, 0);
  endtask

  task automatic t_hopper();
    int p0;
    hopper_empty = 1'b1;
    cyc(4);
    check(fault_code == 3'd1, "R6 idle code", fault_code, 1);
    check(motor_en == 1'b0, "R6 motor off", motor_en, 0);
    hopper_empty = 1'b0;
    cyc(4);
    check(fault_code == 3'd1, "R10 held after sensor drop", fault_code, 1);
    clear_fault();
    p0 = pick_cnt;
    request();
    wait_picks(p0 + 1);
    cyc(3);
    hopper_empty = 1'b1;
    cyc(4);
    check(fault_code == 3'd1, "R6 feed code", fault_code, 1);
    check(motor_en == 1'b0, "R6 feed motor off", motor_en, 0);
    hopper_empty = 1'b0;
    cyc(4);
    clear_fault();
  endtask

  task automatic t_stacker();
    int p0 = pick_cnt;
    request();
    wait_picks(p0 + 1);
    card_sense = 1'b1;
    cyc(5);
    stacker_full = 1'b1;
    cyc(4);
    check(fault_code == 3'd2, "R7 code", fault_code, 2);
    check(motor_en == 1'b0, "R7 motor off", motor_en, 0);
    card_sense = 1'b0;
    stacker_full = 1'b0;
    cyc(4);
    clear_fault();
  endtask

  task automatic t_both();
    hopper_empty = 1'b1;
    stacker_full = 1'b1;
    cyc(4);
    check(fault_code == 3'd2, "R9 stacker over hopper", fault_code, 2);
    hopper_empty = 1'b0;
    stacker_full = 1'b0;
    cyc(4);
    clear_fault();
  endtask

  task automatic t_jam();
    int p0 = pick_cnt;
    request();
    wait_picks(p0 + 1);
    card_sense = 1'b1;
    cyc(20);
    check(fault_code == 3'd0, "R8 no early jam", fault_code, 0);
    check(motor_en == 1'b1, "R8 still reading", motor_en, 1);
    cyc(20);
    check(fault_code == 3'd4, "R8 jam code", fault_code, 4);
    check(motor_en == 1'b0, "R8 motor off", motor_en, 0);
    card_sense = 1'b0;
    cyc(4);
    clear_fault();
  endtask

  task automatic t_jam_priority();
    int p0 = pick_cnt;
    max_transit = 16'd1;
    request();
    wait_picks(p0 + 1);
    card_sense = 1'b1;
    @(negedge clk) stacker_full = 1'b1;
    cyc(6);
    check(fault_code == 3'd4, "R9 jam over stacker", fault_code, 4);
    card_sense = 1'b0;
    stacker_full = 1'b0;
    max_transit = 16'd30;
    cyc(4);
    clear_fault();
  endtask

  task automatic t_clear_ignored();
    int p0 = pick_cnt, d0 = done_cnt;
    clear_fault();
    cyc(3);
    check(pick_cnt == p0, "R11 no pick from clear", pick_cnt - p0, 0);
    check(motor_en == 1'b0, "R11 motor stays off", motor_en, 0);
    request();
    wait_picks(p0 + 1);
    card_sense = 1'b1;
    cyc(4);
    clear_fault();
    check(motor_en == 1'b1, "R11 read not aborted", motor_en, 1);
    card_sense = 1'b0;
    cyc(6);
    check(done_cnt - d0 == 1, "R11 card completes", done_cnt - d0, 1);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_normal();
    t_pick_fail();
    t_retry_clear();
    t_hopper();
    t_stacker();
    t_both();
    t_jam();
    t_jam_priority();
    t_clear_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule